// File: doc/BRIEF.md
# Serial Polyphase FIR Interpolator

This block raises the sample rate of a real fixed-point stream by an integer factor. Each accepted input sample produces a run of scalar output samples, one for each polyphase branch of the tap set. The whole interpolation is computed on one shared multiply-accumulate slice. The user-facing build parameters are the tap count, the interpolation factor and the guaranteed spacing between valid inputs. Zero-padded taps, the number of multipliers and the output pacing are all derived from these.

The upstream source must leave at least the configured gap between valid samples, and it watches `ready` to know when the next one may be offered. The phases run in order 0, 1, and so on up to the last branch. Branch `p` weights the newest sample with tap `p`, the one before it with tap `p+R`, and so on further back. The full-precision sum is shifted, rounded and saturated to the output width. A synchronous local clear abandons the sample in flight and empties the history.

Top module: `interp_fir_serial`

## Requirements
- R1: For every accepted input x[n], the block emits INTERP outputs in phase order 0..INTERP-1. The value of phase p is the cast of the sum over j of h[p+j*INTERP]*x[n-j], and a tap index at or beyond NUM_TAPS counts as zero. This equals zero-stuffing the input by INTERP and convolving with h.
- R2: Let SLOT = floor(IN_GAP/INTERP). The phase-p output of a sample accepted at a clock edge is presented with outValid high exactly SLOT*(p+1) cycles after that edge. Each outValid pulse lasts one cycle.
- R3: ready goes low in the cycle after an input is accepted. It stays low until the cycle in which the last multiply step of the last phase runs, and it is high in that cycle. Back-to-back inputs can therefore be accepted every INTERP*SLOT cycles.
- R4: A valid input offered while ready is low is discarded. It does not enter the sample history and it does not disturb the outputs in progress.
- R5: Cycles with inValid low leave the sample history unchanged, whatever value is on inData.
- R6: A high localClr on a clock edge has four effects. No further outputs of the sample in flight appear, the history is zeroed, outValid is low, and ready is high from the next cycle on. An input offered in the same cycle as the clear is discarded.
- R7: With ROUND_MODE = RND_HALF_UP, the output is (acc + 2^(OUT_SHIFT-1)) arithmetically shifted right by OUT_SHIFT, which rounds halves toward plus infinity. With RND_FLOOR, the sum is shifted without the bias.
- R8: Results above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) are clamped to those limits. The accumulator is DATA_W+COEF_W+clog2(NUM_TAPS) bits wide, so it never wraps before the clamp.
- R9: While rst_n is low, and right after it is released, outValid is 0, outData is 0 and ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| localClr | input | 1 | Synchronous clear of history, accumulator and valid pipeline |
| inValid | input | 1 | Input sample strobe |
| inData | input | DATA_W | Signed input sample |
| ready | output | 1 | A new sample may be offered in this cycle |
| outValid | output | 1 | Output sample strobe |
| outData | output | OUT_W | Signed interpolated sample |

## Verification
Each accepted input is timed by the clock edge that captures it. Phase p of that input is due SLOT*(p+1) cycles after the edge. ready must read low from the next cycle until INTERP*SLOT-1 cycles after the edge, and it must be high in that cycle. The effect of a clear is due on the cycle right after the clear edge. The bench reads the design's outputs on falling edges only. It queues every expected output together with the cycle number in which it is due. It flags any pulse that comes early, comes late, is missing or is not expected. It also checks ready against its own predicted busy window on every cycle.

// File: rtl/interp_pkg.sv
`timescale 1ns/1ps
package interp_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic shift;  // load a new sample into the history
    logic mac;    // run one multiply step this cycle
    logic first;  // first step of a phase: restart accumulation
    logic last;   // last step of a phase: emit a result
  } ctrl_t;

  typedef enum logic {
    RND_FLOOR   = 1'b0,
    RND_HALF_UP = 1'b1
  } round_e;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int idxWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/interp_ctrl.sv
`timescale 1ns/1ps
module interp_ctrl
  import interp_pkg::*;
#(
  parameter int INTERP  = 4,
  parameter int SLOT    = 2,
  parameter int PHASE_W = 2,
  parameter int STEP_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               localClr,
  input  logic               inValid,
  output logic               ready,
  output ctrl_t              strobes,
  output logic [PHASE_W-1:0] phase,
  output logic [STEP_W-1:0]  step
);

  logic busy;
  logic lastStep;
  logic finalStep;
  logic accept;

  assign lastStep  = busy && (step == STEP_W'(SLOT - 1));
  assign finalStep = lastStep && (phase == PHASE_W'(INTERP - 1));
  assign ready     = !busy || finalStep;
  assign accept    = inValid && ready && !localClr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
      step  <= '0;
    end else if (localClr) begin
      busy  <= 1'b0;
      phase <= '0;
      step  <= '0;
    end else if (busy && !finalStep) begin
      if (lastStep) begin
        phase <= phase + 1'b1;
        step  <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end else begin
      busy  <= accept;
      phase <= '0;
      step  <= '0;
    end
  end

  always_comb begin
    strobes.shift = accept;
    strobes.mac   = busy && !localClr;
    strobes.first = (step == '0);
    strobes.last  = lastStep;
  end

  // R3: an accepted sample blocks the next offer on the following cycle
  assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && ready && !localClr) |=> !ready);

  // R6: after a clear the sequencer is idle and accepting
  assert_clear_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    localClr |=> ready);

  // R4: an offer while blocked does not end the sample in flight early
  assert_ignore_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !localClr) |=> (phase != '0 || step != '0 || ready));

  // R1: the phase counter never leaves its range
  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(phase) < INTERP));

endmodule

// File: rtl/interp_datapath.sv
`timescale 1ns/1ps
module interp_datapath
  import interp_pkg::*;
#(
  parameter int     DATA_W     = 16,
  parameter int     COEF_W     = 16,
  parameter int     OUT_W      = 16,
  parameter int     NUM_TAPS   = 16,
  parameter int     INTERP     = 4,
  parameter int     TAPS       = 4,
  parameter int     MULTS      = 2,
  parameter int     SLOT       = 2,
  parameter int     OUT_SHIFT  = 13,
  parameter round_e ROUND_MODE = RND_HALF_UP,
  parameter logic signed [COEF_W-1:0] COEFS [NUM_TAPS] = '{default: '0},
  parameter int     PHASE_W    = 2,
  parameter int     STEP_W     = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     localClr,
  input  ctrl_t                    strobes,
  input  logic [PHASE_W-1:0]       phase,
  input  logic [STEP_W-1:0]        step,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outData
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + idxWidth(NUM_TAPS);
  localparam int HALF_POS = (OUT_SHIFT > 0) ? OUT_SHIFT - 1 : 0;
  localparam logic signed [ACC_W:0] HALF =
    (ROUND_MODE == RND_HALF_UP && OUT_SHIFT > 0) ? (ACC_W+1)'(64'sd1 <<< HALF_POS) : '0;
  localparam logic signed [ACC_W:0] OUT_MAX = (ACC_W+1)'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W:0] OUT_MIN = -OUT_MAX - 1;

  logic signed [DATA_W-1:0] dly [TAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [PROD_W-1:0] prods [MULTS];
  logic signed [ACC_W-1:0]  partial;
  logic signed [ACC_W-1:0]  accNext;
  logic signed [ACC_W:0]    biased;
  logic signed [ACC_W:0]    scaled;
  logic signed [OUT_W-1:0]  castVal;

  // One multiplier per lane; lane m covers tap slot step*MULTS+m of the phase.
  for (genvar m = 0; m < MULTS; m++) begin : g_lane
    int tapIdx;
    int coefIdx;
    logic signed [DATA_W-1:0] sample;
    logic signed [COEF_W-1:0] coef;

    always_comb begin
      tapIdx  = int'(step) * MULTS + m;
      coefIdx = int'(phase) + tapIdx * INTERP;
      sample  = '0;
      coef    = '0;
      for (int t = 0; t < TAPS; t++) begin
        if (t == tapIdx) sample = dly[t];
      end
      for (int c = 0; c < NUM_TAPS; c++) begin
        if (c == coefIdx) coef = COEFS[c];
      end
      prods[m] = PROD_W'(sample) * PROD_W'(coef);
    end
  end

  always_comb begin
    partial = '0;
    for (int m = 0; m < MULTS; m++) begin
      partial = partial + ACC_W'(prods[m]);
    end
    accNext = (strobes.first ? '0 : acc) + partial;
  end

  // Output cast: optional half bias, arithmetic shift, clamp.
  always_comb begin
    biased = (ACC_W+1)'(accNext) + HALF;
    scaled = biased >>> OUT_SHIFT;
    if (scaled > OUT_MAX) begin
      castVal = OUT_MAX[OUT_W-1:0];
    end else if (scaled < OUT_MIN) begin
      castVal = OUT_MIN[OUT_W-1:0];
    end else begin
      castVal = scaled[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < TAPS; t++) dly[t] <= '0;
      acc      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else if (localClr) begin
      for (int t = 0; t < TAPS; t++) dly[t] <= '0;
      acc      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobes.mac && strobes.last;
      if (strobes.shift) begin
        dly[0] <= inData;
        for (int t = 1; t < TAPS; t++) dly[t] <= dly[t-1];
      end
      if (strobes.mac) begin
        acc <= accNext;
        if (strobes.last) outData <= castVal;
      end
    end
  end

  // R5: history holds when no sample is loaded
  assert_hold_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.shift && !localClr) |=> ($stable(dly[0]) && $stable(dly[TAPS-1])));

  // R6: a clear empties the newest history slot and the valid pipeline
  assert_clear_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    localClr |=> (!outValid && dly[0] == '0));

  // R2: a result follows a finishing multiply step
  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.mac || !strobes.last) |=> !outValid);

  // R2: valid pulses are single-cycle whenever a phase takes more than one cycle
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (SLOT > 1 && outValid) |=> !outValid);

endmodule

// File: rtl/interp_fir_serial.sv
`timescale 1ns/1ps
module interp_fir_serial
  import interp_pkg::*;
#(
  parameter int     DATA_W     = 16,
  parameter int     COEF_W     = 16,
  parameter int     OUT_W      = 16,
  parameter int     NUM_TAPS   = 16,
  parameter int     INTERP     = 4,
  parameter int     IN_GAP     = 8,
  parameter int     OUT_SHIFT  = 13,
  parameter round_e ROUND_MODE = RND_HALF_UP,
  parameter logic signed [COEF_W-1:0] COEFS [NUM_TAPS] = '{
    16'sd100,  -16'sd300, 16'sd500,  16'sd1200,
    16'sd2500, 16'sd4200, 16'sd6000, 16'sd7500,
    16'sd7500, 16'sd6000, 16'sd4200, 16'sd2500,
    16'sd1200, 16'sd500,  -16'sd300, 16'sd100
  }
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     localClr,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     ready,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outData
);

  localparam int TAPS    = ceilDiv(NUM_TAPS, INTERP);
  localparam int SLOT    = IN_GAP / INTERP;
  localparam int MULTS   = ceilDiv(TAPS, SLOT);
  localparam int PHASE_W = idxWidth(INTERP);
  localparam int STEP_W  = idxWidth(SLOT);

  initial begin
    if (SLOT < 1 || INTERP < 2) $error("IN_GAP must be at least INTERP and INTERP at least 2");
  end

  ctrl_t              strobes;
  logic [PHASE_W-1:0] phase;
  logic [STEP_W-1:0]  step;

  interp_ctrl #(
    .INTERP (INTERP),
    .SLOT   (SLOT),
    .PHASE_W(PHASE_W),
    .STEP_W (STEP_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .localClr(localClr),
    .inValid (inValid),
    .ready   (ready),
    .strobes (strobes),
    .phase   (phase),
    .step    (step)
  );

  interp_datapath #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .OUT_W     (OUT_W),
    .NUM_TAPS  (NUM_TAPS),
    .INTERP    (INTERP),
    .TAPS      (TAPS),
    .MULTS     (MULTS),
    .SLOT      (SLOT),
    .OUT_SHIFT (OUT_SHIFT),
    .ROUND_MODE(ROUND_MODE),
    .COEFS     (COEFS),
    .PHASE_W   (PHASE_W),
    .STEP_W    (STEP_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .localClr(localClr),
    .strobes (strobes),
    .phase   (phase),
    .step    (step),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );

endmodule

// File: tb/interp_fir_serial_test.sv
`timescale 1ns/1ps
module interp_fir_serial_test;

  localparam int DATA_W = 16;
  localparam int OUT_W  = 16;
  localparam int L      = 16;
  localparam int R      = 4;
  localparam int N      = 8;
  localparam int SHIFT  = 13;
  localparam int T      = (L + R - 1) / R;
  localparam int SLOT   = N / R;
  localparam int CF [L] = '{100, -300, 500, 1200, 2500, 4200, 6000, 7500,
                            7500, 6000, 4200, 2500, 1200, 500, -300, 100};
  localparam logic signed [15:0] CFV [L] = '{
    16'sd100,  -16'sd300, 16'sd500,  16'sd1200, 16'sd2500, 16'sd4200, 16'sd6000, 16'sd7500,
    16'sd7500, 16'sd6000, 16'sd4200, 16'sd2500, 16'sd1200, 16'sd500,  -16'sd300, 16'sd100};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic localClr = 1'b0;
  logic inValid = 1'b0;
  logic signed [DATA_W-1:0] inData = '0;
  logic ready;
  logic outValid;
  logic signed [OUT_W-1:0] outData;

  interp_fir_serial #(
    .NUM_TAPS(L), .INTERP(R), .IN_GAP(N), .OUT_SHIFT(SHIFT), .COEFS(CFV)
  ) uut (
    .clk(clk), .rst_n(rst_n), .localClr(localClr), .inValid(inValid),
    .inData(inData), .ready(ready), .outValid(outValid), .outData(outData)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int hist [T];
  int expVal [$];
  int expDue [$];
  int busyEnd = 0;
  bit monOn = 1'b0;
  string curReq = "R1";
  int seed = 12345;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int model(input int p);
    longint acc = 0;
    for (int j = 0; j < T; j++) begin
      if (p + j * R < L) acc += longint'(CF[p + j * R]) * longint'(hist[j]);
    end
    acc = (acc + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;   // R7 half-up rounding
    if (acc > 32767) acc = 32767;                       // R8 clamp
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  // Output and ready monitor, sampled on falling edges.
  always @(negedge clk) begin
    if (monOn) begin
      check(ready == (cyc >= busyEnd), "R3", int'(ready), int'(cyc >= busyEnd), "ready");
      if (expDue.size() > 0 && cyc > expDue[0]) begin
        check(1'b0, "R2", 0, 1, "missing outValid");
        void'(expVal.pop_front());
        void'(expDue.pop_front());
      end
      if (outValid) begin
        if (expDue.size() == 0) begin
          check(1'b0, "R2", 1, 0, "unexpected outValid");
        end else begin
          check(cyc == expDue[0], "R2", cyc, expDue[0], "output cycle");
          check(int'(outData) == expVal[0], curReq, int'(outData), expVal[0], "output value");
          void'(expVal.pop_front());
          void'(expDue.pop_front());
        end
      end
    end
  end

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return int'(signed'(seed[30:15]));
  endfunction

  task automatic sendSample(input int x, input int idle);
    @(negedge clk);
    while (!ready) @(negedge clk);
    inValid = 1'b1;
    inData = DATA_W'(x);
    @(posedge clk);
    #1;
    for (int j = T - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
    for (int p = 0; p < R; p++) begin
      expVal.push_back(model(p));
      expDue.push_back(cyc + SLOT * (p + 1));
    end
    busyEnd = cyc + R * SLOT - 1;
    @(negedge clk);
    inValid = 1'b0;
    inData = DATA_W'(nextRand());   // R5: data on idle cycles must not matter
    for (int k = 0; k < idle; k++) begin
      @(negedge clk);
      inData = DATA_W'(nextRand());
    end
  endtask

  task automatic clearNow();
    @(negedge clk);
    localClr = 1'b1;
    inValid = 1'b1;                 // R6: offer in the clear cycle is dropped
    inData = 16'sd20000;
    @(posedge clk);
    #1;
    expVal.delete();
    expDue.delete();
    for (int j = 0; j < T; j++) hist[j] = 0;
    busyEnd = 0;
    @(negedge clk);
    localClr = 1'b0;
    inValid = 1'b0;
    check(outValid == 1'b0, "R6", int'(outValid), 0, "outValid after clear");
    check(ready == 1'b1, "R6", int'(ready), 1, "ready after clear");
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && expDue.size() > 0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "R2", 0, 1, "watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < T; j++) hist[j] = 0;
    repeat (3) @(negedge clk);
    // R9: state while in reset
    check(outValid == 1'b0, "R9", int'(outValid), 0, "outValid in reset");
    check(ready == 1'b1, "R9", int'(ready), 1, "ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R9", int'(outValid), 0, "outValid after reset");
    check(int'(outData) == 0, "R9", int'(outData), 0, "outData after reset");
    check(ready == 1'b1, "R9", int'(ready), 1, "ready after reset");
    monOn = 1'b1;

    // R1: impulse exposes every tap, back-to-back at the tightest spacing
    curReq = "R1";
    sendSample(8192, 0);
    for (int k = 0; k < T; k++) sendSample(0, 0);
    // R1: step and ramp
    for (int k = 0; k < 6; k++) sendSample(5000, 0);
    for (int k = 0; k < 10; k++) sendSample(k * 3000 - 15000, k % 3);

    // R5: long idle gaps with changing data on the bus
    curReq = "R5";
    for (int k = 0; k < 30; k++) sendSample(nextRand() / 4, 3 + (k % 7));

    // R7: exact half cases after a clean history
    drain();
    clearNow();
    curReq = "R7";
    sendSample(1024, 0);            // phase 0 is 12.5, rounds to 13
    drain();
    clearNow();
    sendSample(-1024, 0);           // phase 0 is -12.5, rounds to -12
    for (int k = 0; k < 20; k++) sendSample(nextRand() / 8, k % 2);

    // R8: full-scale inputs drive both clamps
    curReq = "R8";
    for (int k = 0; k < 6; k++) sendSample(32767, 0);
    for (int k = 0; k < 6; k++) sendSample(-32768, 0);
    for (int k = 0; k < 4; k++) sendSample(32767, 1);

    // R4: offers while ready is low are dropped
    curReq = "R4";
    for (int s = 0; s < 5; s++) begin
      sendSample(7000 - s * 2500, 0);
      for (int k = 0; k < 3; k++) begin
        check(ready == 1'b0, "R4", int'(ready), 0, "blocked before junk offer");
        inValid = 1'b1;
        inData = DATA_W'(nextRand());
        @(negedge clk);
      end
      inValid = 1'b0;
    end
    drain();

    // R6: clear in the middle of a sample, then an impulse shows an empty history
    curReq = "R6";
    sendSample(12000, 0);
    sendSample(-9000, 0);
    clearNow();
    sendSample(8192, 0);
    for (int k = 0; k < T; k++) sendSample(0, 0);
    sendSample(30000, 0);
    repeat (3) @(negedge clk);
    clearNow();
    for (int k = 0; k < 5; k++) sendSample(nextRand(), 0);
    drain();

    check(expDue.size() == 0, "R2", expDue.size(), 0, "outputs left pending");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule